// File: doc/BRIEF.md
# Soft-Decision Rate-1/2 Constraint-Length-7 Viterbi Decoder

This block decodes terminated blocks of the rate-1/2, K=7 convolutional code with octal generators 171 and 133. A block starts with a one-cycle `blk_start` pulse that carries the number of information bits L. The block then takes exactly L+6 pairs of 4-bit signed soft symbols, one pair per cycle while `sym_valid` is high. The last six pairs belong to the all-zero tail that drives the encoder back to state 0. For each pair the decoder forms four correlation branch metrics. It then runs add-compare-select over all 64 trellis states, keeps the path with the larger metric and stores one decision bit per state per step.

After the final tail pair, the decoder traces back through the stored decisions from state 0, one step per cycle. It then presents the L recovered information bits in their original order, one per cycle, with `bit_valid` high and `bit_last` marking the final bit.

The controller is a four-state machine. `ST_IDLE` waits for `blk_start` and moves to `ST_ACS`. `ST_ACS` consumes symbol pairs and moves to `ST_TRACE` on the pair that completes L+6 steps. `ST_TRACE` walks the survivor store from step L+5 down to step 0 and moves to `ST_EMIT` after step 0. `ST_EMIT` drives out one bit per cycle and returns to `ST_IDLE` after bit L.

Top module: `vit_k7_decoder`

## Requirements
- R1: While reset is asserted and on the first cycle after reset, `bit_valid` and `bit_last` are 0.
- R2: The code uses register r = {u, s}, where u is the new bit and s[5] is the most recent earlier bit. The first symbol of a pair (`sym_g0`) is the parity of r masked with octal 171. The second (`sym_g1`) is the parity of r masked with octal 133. The next state is {u, s[5:1]}. With noiseless input the decoder returns the encoded bits exactly.
- R3: Soft inputs are two's complement. A positive value favours code bit 0 and a negative value favours code bit 1. The branch metric is ±sym_g0 ± sym_g1, with + for an expected 0 and − for an expected 1. Any nonzero magnitude gives exact decoding on noiseless input.
- R4: At block start, state 0 has path metric 0 and every other state has a strongly negative metric. Traceback starts at state 0 and always ends at state 0.
- R5: Each state keeps the predecessor with the larger accumulated metric. On a tie it keeps the predecessor whose oldest bit is 0, so a block of all-zero soft symbols decodes to all zeros.
- R6: `blk_len` is sampled with `blk_start` in `ST_IDLE`. A value of 0 is treated as 1, and a value above MAX_INFO (default 26) is treated as MAX_INFO. The block consumes exactly L+6 pairs, and cycles with `sym_valid` low are not counted.
- R7: Exactly L bits come out, on consecutive cycles and in original order, with `bit_last` high only with the L-th bit.
- R8: Any two sign-flipped symbols within a block are corrected.
- R9: `blk_start` is ignored while a block is in progress, and `sym_valid` is ignored outside `ST_ACS`.
- R10: Path metrics cannot overflow for any input values, including -8, at the largest block length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_start | input | 1 | Opens a new block when the decoder is idle |
| blk_len | input | 5 | Information bits in the block, sampled with `blk_start` |
| sym_valid | input | 1 | A symbol pair is present this cycle |
| sym_g0 | input | 4 | Signed soft value for the first generator's code bit |
| sym_g1 | input | 4 | Signed soft value for the second generator's code bit |
| bit_valid | output | 1 | A decoded bit is on `bit_out` |
| bit_out | output | 1 | Decoded information bit |
| bit_last | output | 1 | Marks the final decoded bit of the block |

## Verification
The overflow check assumes soft inputs stay within 4-bit two's complement and that the block never exceeds MAX_INFO+6 steps. Length clamping guarantees the step bound, and the bench drives values from -8 to +7, including a full block at -8/+7. The check that traceback returns to state 0 depends on every state except 0 starting far below any reachable metric. The check that `blk_start` is ignored assumes the pulse may arrive in any state, so the bench fires it mid-block with a different length. The bench also holds `sym_valid` high with junk values during idle, traceback and output.

// File: rtl/vit_pkg.sv
package vit_pkg;
    localparam int CONSTR = 7;
    localparam int MEM    = CONSTR - 1;
    localparam int NSTATE = 1 << MEM;
    localparam logic [CONSTR-1:0] GEN_A = 7'o171;
    localparam logic [CONSTR-1:0] GEN_B = 7'o133;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACS,
        ST_TRACE,
        ST_EMIT
    } vit_state_e;

    // Expected code bits {first, second} for input bit u leaving state st.
    function automatic logic [1:0] code_pair(input logic u, input logic [MEM-1:0] st);
        logic [CONSTR-1:0] r;
        r = {u, st};
        return {^(r & GEN_A), ^(r & GEN_B)};
    endfunction
endpackage

// File: rtl/vit_bmu.sv
module vit_bmu #(
    parameter int SOFT_W = 4,
    localparam int BM_W  = SOFT_W + 2
) (
    input  logic signed [SOFT_W-1:0] sd0,
    input  logic signed [SOFT_W-1:0] sd1,
    output logic signed [BM_W-1:0]   bm [4]
);
    logic signed [BM_W-1:0] a;
    logic signed [BM_W-1:0] b;

    assign a = {{2{sd0[SOFT_W-1]}}, sd0};
    assign b = {{2{sd1[SOFT_W-1]}}, sd1};

    // Index {c0,c1}: an expected 1 negates the matching soft value.
    for (genvar k = 0; k < 4; k++) begin : g_bm
        localparam bit NEG0 = ((k / 2) % 2) == 1;
        localparam bit NEG1 = (k % 2) == 1;
        assign bm[k] = (NEG0 ? -a : a) + (NEG1 ? -b : b);
    end
endmodule

// File: rtl/vit_acs_bank.sv
module vit_acs_bank
    import vit_pkg::*;
#(
    parameter int BM_W = 6,
    parameter int PM_W = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   init,
    input  logic                   step,
    input  logic signed [BM_W-1:0] bm [4],
    output logic [NSTATE-1:0]      dec_col
);
    localparam logic signed [PM_W-1:0] PM_LOW   = PM_W'(-(2 ** (PM_W - 2)));
    localparam logic signed [PM_W-1:0] PM_FLOOR = PM_W'(-(2 ** (PM_W - 2)) - (2 ** (PM_W - 3)));

    logic signed [PM_W-1:0] pm   [NSTATE];
    logic signed [PM_W-1:0] nxt  [NSTATE];
    logic signed [PM_W-1:0] bm_x [4];

    for (genvar i = 0; i < 4; i++) begin : g_ext
        assign bm_x[i] = {{(PM_W - BM_W){bm[i][BM_W-1]}}, bm[i]};
    end

    // State g = {u, g[4:0]} is reached from {g[4:0], b}; the decision is b.
    for (genvar g = 0; g < NSTATE; g++) begin : g_acs
        localparam logic           U   = (g >= NSTATE / 2);
        localparam logic [MEM-1:0] P0  = MEM'((g * 2) % NSTATE);
        localparam logic [MEM-1:0] P1  = MEM'(((g * 2) % NSTATE) + 1);
        localparam logic [1:0]     CP0 = code_pair(U, P0);
        localparam logic [1:0]     CP1 = code_pair(U, P1);

        logic signed [PM_W-1:0] cand0;
        logic signed [PM_W-1:0] cand1;

        assign cand0      = pm[P0] + bm_x[CP0];
        assign cand1      = pm[P1] + bm_x[CP1];
        assign dec_col[g] = (cand1 > cand0);
        assign nxt[g]     = dec_col[g] ? cand1 : cand0;

        // R10
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pm[g] >= PM_FLOOR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSTATE; s++) pm[s] <= (s == 0) ? '0 : PM_LOW;
        end else if (init) begin
            for (int s = 0; s < NSTATE; s++) pm[s] <= (s == 0) ? '0 : PM_LOW;
        end else if (step) begin
            for (int s = 0; s < NSTATE; s++) pm[s] <= nxt[s];
        end
    end
endmodule

// File: rtl/vit_trace.sv
module vit_trace
    import vit_pkg::*;
#(
    parameter int MAX_STEPS = 32,
    localparam int IDX_W    = $clog2(MAX_STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [NSTATE-1:0] dec_col,
    input  logic              tb_load,
    input  logic              tb_run,
    input  logic              tb_keep,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              ob_bit
);
    logic [NSTATE-1:0]    surv [MAX_STEPS];
    logic [MAX_STEPS-1:0] obuf;
    logic [MEM-1:0]       cur;

    always_ff @(posedge clk) begin
        if (wr_en) surv[wr_idx] <= dec_col;
    end

    // cur is the state after step rd_idx; its top bit is that step's input.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur  <= '0;
            obuf <= '0;
        end else if (tb_load) begin
            cur <= '0;
        end else if (tb_run) begin
            cur <= {cur[MEM-2:0], surv[rd_idx][cur]};
            if (tb_keep) obuf[rd_idx] <= cur[MEM-1];
        end
    end

    assign ob_bit = obuf[rd_idx];

    // R4
    origin_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_run && rd_idx == '0) |=> (cur == '0));
endmodule

// File: rtl/vit_k7_decoder.sv
module vit_k7_decoder
    import vit_pkg::*;
#(
    parameter int SOFT_W   = 4,
    parameter int MAX_INFO = 26,
    localparam int LEN_W   = $clog2(MAX_INFO + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    blk_start,
    input  logic [LEN_W-1:0]        blk_len,
    input  logic                    sym_valid,
    input  logic signed [SOFT_W-1:0] sym_g0,
    input  logic signed [SOFT_W-1:0] sym_g1,
    output logic                    bit_valid,
    output logic                    bit_out,
    output logic                    bit_last
);
    localparam int MAX_STEPS = MAX_INFO + MEM;
    localparam int IDX_W     = $clog2(MAX_STEPS);
    localparam int CNT_W     = IDX_W + 1;
    localparam int BM_W      = SOFT_W + 2;
    localparam int PM_W      = $clog2(MAX_STEPS * (2 ** SOFT_W)) + 4;

    vit_state_e        st, st_nx;
    logic [LEN_W-1:0]  n_info, len_fix;
    logic [CNT_W-1:0]  idx, n_steps, info_ext;
    logic              step_last, emit_last;
    logic              acs_init, acs_step, tb_load, tb_run, tb_keep;
    logic              ob_bit;
    logic signed [BM_W-1:0] bm [4];
    logic [NSTATE-1:0] dec_col;

    always_comb begin
        if (blk_len == '0)                       len_fix = LEN_W'(1);
        else if (blk_len > LEN_W'(MAX_INFO))     len_fix = LEN_W'(MAX_INFO);
        else                                     len_fix = blk_len;
    end

    assign info_ext  = CNT_W'(n_info);
    assign n_steps   = info_ext + CNT_W'(MEM);
    assign step_last = (idx == n_steps - 1'b1);
    assign emit_last = (idx == info_ext - 1'b1);
    assign acs_init  = (st == ST_IDLE) && blk_start;
    assign acs_step  = (st == ST_ACS) && sym_valid;
    assign tb_load   = acs_step && step_last;
    assign tb_run    = (st == ST_TRACE);
    assign tb_keep   = (idx < info_ext);

    vit_bmu #(.SOFT_W(SOFT_W)) u_bmu (
        .sd0 (sym_g0),
        .sd1 (sym_g1),
        .bm  (bm)
    );

    vit_acs_bank #(.BM_W(BM_W), .PM_W(PM_W)) u_acs (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (acs_init),
        .step    (acs_step),
        .bm      (bm),
        .dec_col (dec_col)
    );

    vit_trace #(.MAX_STEPS(MAX_STEPS)) u_trace (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acs_step),
        .wr_idx  (idx[IDX_W-1:0]),
        .dec_col (dec_col),
        .tb_load (tb_load),
        .tb_run  (tb_run),
        .tb_keep (tb_keep),
        .rd_idx  (idx[IDX_W-1:0]),
        .ob_bit  (ob_bit)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (blk_start)              st_nx = ST_ACS;
            ST_ACS:   if (sym_valid && step_last) st_nx = ST_TRACE;
            ST_TRACE: if (idx == '0)              st_nx = ST_EMIT;
            ST_EMIT:  if (emit_last)              st_nx = ST_IDLE;
            default:                              st_nx = ST_IDLE;
        endcase
    end

    // State register and step counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            idx    <= '0;
            n_info <= LEN_W'(1);
        end else begin
            st <= st_nx;
            unique case (st)
                ST_IDLE: begin
                    if (blk_start) begin
                        n_info <= len_fix;
                        idx    <= '0;
                    end
                end
                ST_ACS: begin
                    if (sym_valid && !step_last) idx <= idx + 1'b1;
                end
                ST_TRACE: begin
                    if (idx != '0) idx <= idx - 1'b1;
                end
                ST_EMIT: begin
                    idx <= emit_last ? '0 : idx + 1'b1;
                end
                default: idx <= '0;
            endcase
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_valid <= 1'b0;
            bit_out   <= 1'b0;
            bit_last  <= 1'b0;
        end else begin
            bit_valid <= (st == ST_EMIT);
            bit_out   <= (st == ST_EMIT) ? ob_bit : 1'b0;
            bit_last  <= (st == ST_EMIT) && emit_last;
        end
    end

    // R7
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_last |-> bit_valid);

    // R7
    last_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_last |=> !bit_valid);

    // R6
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACS) |-> (idx < n_steps));

    // R6
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (n_info != '0) && (n_info <= LEN_W'(MAX_INFO)));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st != ST_IDLE) && blk_start) |=> $stable(n_info));
endmodule

// File: tb/vit_k7_decoder_test.sv
module vit_k7_decoder_test;
    localparam int SW   = 4;
    localparam int MAXI = 26;
    localparam int LW   = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic blk_start = 1'b0;
    logic [LW-1:0] blk_len = '0;
    logic sym_valid = 1'b0;
    logic signed [SW-1:0] sym_g0 = '0;
    logic signed [SW-1:0] sym_g1 = '0;
    logic bit_valid, bit_out, bit_last;

    always #10 clk = ~clk;

    vit_k7_decoder #(.SOFT_W(SW), .MAX_INFO(MAXI)) uut (
        .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .blk_len(blk_len),
        .sym_valid(sym_valid), .sym_g0(sym_g0), .sym_g1(sym_g1),
        .bit_valid(bit_valid), .bit_out(bit_out), .bit_last(bit_last)
    );

    int checks = 0;
    int fails = 0;
    int rx_n = 0;
    int last_at = -1;
    int last_cnt = 0;
    logic rx [64];
    int seed = 32'h1234_5678;

    always @(negedge clk) begin
        if (rst_n && bit_valid) begin
            if (rx_n < 64) rx[rx_n] = bit_out;
            if (bit_last) begin
                last_at = rx_n;
                last_cnt++;
            end
            rx_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_data();
        seed = seed * 1103515245 + 12345;
        return seed ^ (seed >>> 11);
    endfunction

    // v0/v1: soft values sent for code bits 0/1; e1/e2: flipped symbol indices.
    task automatic run_block(input int len_req, input int len_eff, input logic [31:0] data,
                             input int v0, input int v1, input int e1, input int e2,
                             input bit erase, input string req);
        int n;
        int errs;
        logic signed [SW-1:0] s0 [40];
        logic signed [SW-1:0] s1 [40];
        logic [5:0] st;
        logic u, c0, c1;
        logic [6:0] r;
        n = len_eff + 6;
        st = '0;
        for (int k = 0; k < n; k++) begin
            u = (k < len_eff) ? data[k] : 1'b0;
            r = {u, st};
            c0 = ^(r & 7'o171);
            c1 = ^(r & 7'o133);
            s0[k] = c0 ? SW'(v1) : SW'(v0);
            s1[k] = c1 ? SW'(v1) : SW'(v0);
            if (erase) begin
                s0[k] = '0;
                s1[k] = '0;
            end
            st = {u, st[5:1]};
        end
        if (e1 >= 0) begin
            if (e1 % 2 == 0) s0[e1/2] = -s0[e1/2]; else s1[e1/2] = -s1[e1/2];
        end
        if (e2 >= 0) begin
            if (e2 % 2 == 0) s0[e2/2] = -s0[e2/2]; else s1[e2/2] = -s1[e2/2];
        end
        // junk pair while idle: must be ignored (R9)
        @(negedge clk);
        sym_valid = 1'b1; sym_g0 = 4'sd7; sym_g1 = -4'sd7;
        @(negedge clk);
        sym_valid = 1'b0;
        rx_n = 0; last_at = -1; last_cnt = 0;
        blk_start = 1'b1; blk_len = LW'(len_req);
        @(negedge clk);
        blk_start = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (k % 5 == 4) begin
                sym_valid = 1'b0;
                @(negedge clk);
            end
            sym_valid = 1'b1;
            sym_g0 = s0[k];
            sym_g1 = s1[k];
            blk_start = (k == 2);
            blk_len = (k == 2) ? LW'(3) : LW'(len_req);
            @(negedge clk);
        end
        blk_start = 1'b0;
        sym_valid = 1'b1; sym_g0 = -4'sd8; sym_g1 = 4'sd5;
        for (int t = 0; t < 200 && rx_n < len_eff; t++) @(negedge clk);
        repeat (4) @(negedge clk);
        sym_valid = 1'b0;
        chk(rx_n == len_eff, "R6", "bit count", rx_n, len_eff);
        errs = 0;
        for (int i = 0; i < len_eff && i < rx_n && i < 64; i++)
            if (rx[i] !== data[i]) errs++;
        chk(errs == 0, req, "bit errors", errs, 0);
        chk(last_cnt == 1 && last_at == len_eff - 1, "R7", "last position", last_at, len_eff - 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n2, p1, p2;
        logic [31:0] d;
        sym_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bit_valid == 1'b0, "R1", "valid in reset", int'(bit_valid), 0);
        chk(bit_last == 1'b0, "R1", "last in reset", int'(bit_last), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bit_valid == 1'b0 && bit_last == 1'b0, "R1", "outputs after reset", int'(bit_valid), 0);
        repeat (40) @(negedge clk);
        sym_valid = 1'b0;
        chk(rx_n == 0, "R9", "bits from idle symbols", rx_n, 0);

        // R2 R3 noiseless patterns
        run_block(26, 26, 32'h0, 7, -7, -1, -1, 1'b0, "R2");
        run_block(26, 26, 32'hFFFF_FFFF, 7, -7, -1, -1, 1'b0, "R2");
        run_block(26, 26, 32'h5555_5555, 3, -3, -1, -1, 1'b0, "R3");
        run_block(1, 1, 32'h1, 1, -1, -1, -1, 1'b0, "R3");
        // R9 covered by mid-block start and junk pairs in every block
        run_block(17, 17, 32'h0001_A5C3, 7, -7, -1, -1, 1'b0, "R9");
        // R10 extreme values
        run_block(26, 26, 32'h02C9_3E71, 7, -8, -1, -1, 1'b0, "R10");
        // R5 all-zero soft symbols decode to zeros
        run_block(26, 26, 32'h0, 7, -7, -1, -1, 1'b1, "R5");
        // R6 length clamping
        run_block(0, 1, 32'h1, 7, -7, -1, -1, 1'b0, "R6");
        run_block(31, 26, 32'h0359_6A1B, 7, -7, -1, -1, 1'b0, "R6");
        // R8 adjacent and distant flips
        run_block(13, 13, 32'h0000_1B2D, 7, -7, 4, 5, 1'b0, "R8");
        run_block(26, 26, 32'h0123_4567, 7, -7, 0, 63, 1'b0, "R8");
        // R4 sweep every length noiseless, varied amplitude
        for (int len = 1; len <= MAXI; len++) begin
            d = next_data();
            run_block(len, len, d, (len % 3 == 0) ? 1 : 5, (len % 3 == 0) ? -1 : -6,
                      -1, -1, 1'b0, "R4");
        end
        // R8 sweep every length with two flips
        for (int len = 1; len <= MAXI; len++) begin
            d = next_data();
            n2 = 2 * (len + 6);
            p1 = (len * 7) % n2;
            p2 = (len * 13 + 5) % n2;
            if (p2 == p1) p2 = (p1 + 1) % n2;
            run_block(len, len, d, 7, -7, p1, p2, 1'b0, "R8");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule